// File: doc/BRIEF.md
# System error interrupt aggregator

This block gathers 64 system-error sources into one interrupt line for a parent interrupt controller. The lowest 21 sources are dedicated level-high wires. The other 43 sources are message-signalled: an agent writes a 32-bit word to a doorbell register, and that word is the absolute number of the source to raise. Each source has one pending bit, held in two 32-bit cause words, and one mask bit, held in two 32-bit mask words.

Software uses a simple 32-bit register bus. It reads the cause words, clears pending bits by writing ones to them, and sets or clears mask bits, where a mask bit of 1 disables its source. The block ORs the unmasked pending causes together. Each time that OR goes from 0 to 1, the block sends the parent a one-cycle pulse, which the parent treats as a rising edge. At initialisation, software writes all ones to both cause words.

Top module: `serr_aggregator`

## Requirements
- R1: While reset is high, and on the first cycle after it, both cause words read 0, both mask words read 0xFFFFFFFF (all sources disabled) and `irq_out` is low.
- R2: Source n is held in word n/32 at bit n%32. The cause words are read at offsets 0x00 and 0x04, and the mask words are written and read at offsets 0x20 and 0x24. A read of any other offset, including the doorbell at 0x30, returns zero.
- R3: A write to a cause word clears each pending bit where the written data has a 1. Bits where the data has a 0 keep their value.
- R4: A wired source n (0 to 20) sets its cause bit on every clock edge where `wired_lvl[n]` is high. A clear written while the input is still high is overridden by the set, so the bit stays pending.
- R5: A write to offset 0x30 with data d, where 21 <= d <= 63, sets cause bit d on the same clock edge.
- R6: A write to offset 0x30 with data below 21, or 64 or larger, changes no cause bit.
- R7: A pending source whose mask bit is 1 produces no pulse on `irq_out`. The cause bit still reads as pending.
- R8: `irq_out` is high for exactly one cycle. It goes high on the clock edge after the OR of unmasked pending causes rises from 0 to 1, whether the rise comes from a new cause or from unmasking a cause that is already pending. A further cause arriving while the OR is already 1 gives no new pulse.
- R9: After the unmasked causes are cleared so that the OR falls to 0, a new unmasked cause produces a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wired_lvl | input | 21 | Level-high inputs for sources 0 to 20 |
| bus_wen | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |
| irq_out | output | 1 | One-cycle pulse to the parent controller |

## Verification
A cause bit changes on the same edge that captures the write or samples the wire, so the bench reads it back combinationally half a cycle after that edge. `irq_out` has one more register stage, so it is checked at the falling edge that follows the next rising edge, and one cycle later it is checked again to confirm it is low. Checks that a case produces no pulse watch `irq_out` at several consecutive falling edges, covering the whole window in which a pulse could have appeared.

// File: rtl/serr_pkg.sv
package serr_pkg;
    localparam int SRC_N   = 64;
    localparam int WORD_W  = 32;
    localparam int WORDS   = SRC_N / WORD_W;
    localparam int WIRED_N = 21;
    localparam int ADDR_W  = 8;
    localparam int IDX_W   = $clog2(SRC_N);

    localparam logic [ADDR_W-1:0] CAUSE_OFF = 8'h00;
    localparam logic [ADDR_W-1:0] MASK_OFF  = 8'h20;
    localparam logic [ADDR_W-1:0] BELL_OFF  = 8'h30;

    typedef struct packed {
        logic              wen;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } bus_wr_t;

    // Byte offset of word w in a bank starting at base
    function automatic logic [ADDR_W-1:0] word_addr(logic [ADDR_W-1:0] base, int w);
        return base + ADDR_W'(4 * w);
    endfunction
endpackage

// File: rtl/serr_doorbell.sv
module serr_doorbell
    import serr_pkg::*;
#(
    parameter int NSRC   = SRC_N,
    parameter int NWIRED = WIRED_N
) (
    input  bus_wr_t           wr,
    output logic [NSRC-1:0]   set_vec
);
    localparam int IW = $clog2(NSRC);

    logic in_range;
    assign in_range = (wr.wdata >= WORD_W'(NWIRED)) && (wr.wdata < WORD_W'(NSRC));

    always_comb begin
        set_vec = '0;
        if (wr.wen && wr.addr == BELL_OFF && in_range)
            set_vec[wr.wdata[IW-1:0]] = 1'b1;
    end
endmodule

// File: rtl/serr_reg_bank.sv
module serr_reg_bank
    import serr_pkg::*;
#(
    parameter int NSRC = SRC_N
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_wr_t          wr,
    input  logic [NSRC-1:0]  set_vec,
    output logic [NSRC-1:0]  cause_q,
    output logic [NSRC-1:0]  mask_q
);
    localparam int NW = NSRC / WORD_W;

    logic [NSRC-1:0] clr_vec;
    logic [NW-1:0]   mask_hit;

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic cause_hit;
        assign cause_hit   = wr.wen && wr.addr == word_addr(CAUSE_OFF, w);
        assign mask_hit[w] = wr.wen && wr.addr == word_addr(MASK_OFF, w);
        assign clr_vec[w*WORD_W +: WORD_W] = cause_hit ? wr.wdata : '0;
    end

    // Set dominates clear so no event is lost
    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            mask_q  <= '1;
        end else begin
            cause_q <= (cause_q & ~clr_vec) | set_vec;
            for (int w = 0; w < NW; w++)
                if (mask_hit[w])
                    mask_q[w*WORD_W +: WORD_W] <= wr.wdata;
        end
    end
endmodule

// File: rtl/serr_pulse_gen.sv
module serr_pulse_gen #(
    parameter int NSRC = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] live,
    output logic            pulse
);
    logic any_now, any_q;
    assign any_now = |live;

    always_ff @(posedge clk) begin
        if (rst) begin
            any_q <= 1'b0;
            pulse <= 1'b0;
        end else begin
            any_q <= any_now;
            pulse <= any_now & ~any_q;
        end
    end
endmodule

// File: rtl/serr_aggregator.sv
module serr_aggregator
    import serr_pkg::*;
#(
    parameter int NSRC   = SRC_N,
    parameter int NWIRED = WIRED_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NWIRED-1:0] wired_lvl,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq_out
);
    localparam int NW = NSRC / WORD_W;

    bus_wr_t         wr;
    logic [NSRC-1:0] bell_set, set_all, cause_q, mask_q;

    assign wr      = '{wen: bus_wen, addr: bus_addr, wdata: bus_wdata};
    assign set_all = {{(NSRC-NWIRED){1'b0}}, wired_lvl} | bell_set;

    serr_doorbell #(.NSRC(NSRC), .NWIRED(NWIRED)) i_bell (
        .wr(wr), .set_vec(bell_set)
    );

    serr_reg_bank #(.NSRC(NSRC)) i_bank (
        .clk(clk), .rst(rst), .wr(wr), .set_vec(set_all),
        .cause_q(cause_q), .mask_q(mask_q)
    );

    serr_pulse_gen #(.NSRC(NSRC)) i_pulse (
        .clk(clk), .rst(rst), .live(cause_q & ~mask_q), .pulse(irq_out)
    );

    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < NW; w++) begin
            if (bus_addr == word_addr(CAUSE_OFF, w)) bus_rdata = cause_q[w*WORD_W +: WORD_W];
            if (bus_addr == word_addr(MASK_OFF, w))  bus_rdata = mask_q[w*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/serr_checker.sv
module serr_checker
    import serr_pkg::*;
#(
    parameter int NSRC   = SRC_N,
    parameter int NWIRED = WIRED_N
) (
    input logic              clk,
    input logic              rst,
    input logic [NWIRED-1:0] wired_lvl,
    input logic              bus_wen,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic              irq_out,
    input logic [NSRC-1:0]   cause_q,
    input logic [NSRC-1:0]   mask_q
);
    localparam int IW = $clog2(NSRC);

    logic live_any, bell_ok, bell_bad;
    assign live_any = (cause_q & ~mask_q) != '0;
    assign bell_ok  = bus_wen && bus_addr == BELL_OFF &&
                      bus_wdata >= WORD_W'(NWIRED) && bus_wdata < WORD_W'(NSRC);
    assign bell_bad = bus_wen && bus_addr == BELL_OFF && !bell_ok;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (cause_q == '0 && mask_q == '1 && !irq_out));

    assert_wired_sets_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cause_q[NWIRED-1:0] & $past(wired_lvl)) == $past(wired_lvl)));

    assert_bell_sets_R5: assert property (@(posedge clk) disable iff (rst)
        bell_ok |=> cause_q[$past(bus_wdata[IW-1:0])]);

    assert_bell_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        bell_bad |=> ((cause_q[NSRC-1:NWIRED] & ~$past(cause_q[NSRC-1:NWIRED])) == '0));

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        irq_out |=> !irq_out);

    assert_pulse_has_cause_R7: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> $past(live_any));

    assert_rise_gives_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(live_any) |=> irq_out);
endmodule

bind serr_aggregator serr_checker #(.NSRC(NSRC), .NWIRED(NWIRED)) i_chk (
    .clk(clk), .rst(rst), .wired_lvl(wired_lvl), .bus_wen(bus_wen),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_out(irq_out),
    .cause_q(cause_q), .mask_q(mask_q)
);

// File: tb/test_serr_aggregator.sv
module test_serr_aggregator;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [20:0] wired_lvl = '0;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    serr_aggregator i_serr_aggregator (
        .clk(clk), .rst(rst), .wired_lvl(wired_lvl), .bus_wen(bus_wen),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    // {doorbell data, expected 64-bit cause}
    localparam logic [95:0] VEC [9] = '{
        {32'd21,         64'h0000_0000_0020_0000},
        {32'd31,         64'h0000_0000_8000_0000},
        {32'd32,         64'h0000_0001_0000_0000},
        {32'd33,         64'h0000_0002_0000_0000},
        {32'd45,         64'h0000_2000_0000_0000},
        {32'd63,         64'h8000_0000_0000_0000},
        {32'd20,         64'h0},
        {32'd64,         64'h0},
        {32'hFFFF_FFFF,  64'h0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd64(output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(8'h00, lo);
        rd(8'h04, hi);
        v = {hi, lo};
    endtask

    task automatic clear_all;
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        logic [63:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state, held in reset
        rd64(v);           chk("R1 cause in reset", v, 64'h0);
        rd(8'h20, r);      chk("R1 mask0 in reset", 64'(r), 64'hFFFF_FFFF);
        rd(8'h24, r);      chk("R1 mask1 in reset", 64'(r), 64'hFFFF_FFFF);
        chk("R1 irq in reset", 64'(irq_out), 64'h0);
        rst = 1'b0;
        @(negedge clk);
        rd64(v);           chk("R1 cause after reset", v, 64'h0);
        chk("R1 irq after reset", 64'(irq_out), 64'h0);

        // R2 mask layout and unmapped reads
        wr(8'h20, 32'h0000_00A5);
        wr(8'h24, 32'h5A00_0000);
        rd(8'h20, r);      chk("R2 mask0 readback", 64'(r), 64'h0000_00A5);
        rd(8'h24, r);      chk("R2 mask1 readback", 64'(r), 64'h5A00_0000);
        rd(8'h30, r);      chk("R2 doorbell reads zero", 64'(r), 64'h0);
        rd(8'h10, r);      chk("R2 unmapped reads zero", 64'(r), 64'h0);
        wr(8'h20, 32'h0);
        wr(8'h24, 32'h0);

        // R5/R6 table walk
        foreach (VEC[i]) begin
            clear_all();
            wr(8'h30, VEC[i][95:64]);
            rd64(v);
            chk((VEC[i][63:0] != 0) ? "R5 doorbell sets source" : "R6 doorbell ignored",
                v, VEC[i][63:0]);
        end

        // R8 pulse timing and no repeat while the OR stays high
        clear_all();
        chk("R8 idle before event", 64'(irq_out), 64'h0);
        wr(8'h30, 32'd40);
        chk("R8 no pulse yet", 64'(irq_out), 64'h0);
        @(negedge clk); chk("R8 pulse high", 64'(irq_out), 64'h1);
        @(negedge clk); chk("R8 pulse one cycle", 64'(irq_out), 64'h0);
        wr(8'h30, 32'd41);
        @(negedge clk); chk("R8 no pulse while pending", 64'(irq_out), 64'h0);
        @(negedge clk); chk("R8 no pulse while pending", 64'(irq_out), 64'h0);

        // R9 pulse again after clear
        wr(8'h04, 32'hFFFF_FFFF);
        repeat (2) @(negedge clk);
        wr(8'h30, 32'd50);
        @(negedge clk); chk("R9 second pulse", 64'(irq_out), 64'h1);

        // R7 masked source, then unmask
        clear_all();
        wr(8'h24, 32'h0004_0000);
        wr(8'h30, 32'd50);
        rd64(v);        chk("R7 masked source pending", v, 64'h0004_0000_0000_0000);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); chk("R7 masked no pulse", 64'(irq_out), 64'h0);
        end
        wr(8'h24, 32'h0);
        @(negedge clk); chk("R8 pulse on unmask", 64'(irq_out), 64'h1);

        // R3 write-one-to-clear
        clear_all();
        wr(8'h30, 32'd22);
        wr(8'h30, 32'd25);
        wr(8'h00, 32'h0040_0000);
        rd(8'h00, r);   chk("R3 clear one bit", 64'(r), 64'h0200_0000);
        wr(8'h00, 32'h0);
        rd(8'h00, r);   chk("R3 zero write keeps", 64'(r), 64'h0200_0000);

        // R4 wired level sets, clear overridden while high
        clear_all();
        @(negedge clk); wired_lvl = 21'h8;
        @(negedge clk);
        rd(8'h00, r);   chk("R4 wired sets", 64'(r), 64'h8);
        wr(8'h00, 32'h8);
        rd(8'h00, r);   chk("R4 clear overridden", 64'(r), 64'h8);
        wired_lvl = '0;
        wr(8'h00, 32'h8);
        rd(8'h00, r);   chk("R4 cleared after drop", 64'(r), 64'h0);
        @(negedge clk); wired_lvl = 21'h10_0000;
        @(negedge clk); wired_lvl = '0;
        rd(8'h00, r);   chk("R4 top wired source", 64'(r), 64'h0010_0000);

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule